// File: doc/BRIEF.md
# Sleep-State Wake Request Qualifier

This block watches a single-wire bus and a local wake-switch input while the transceiver sleeps, and decides when a real wake request has arrived. The bus side sees digitised comparator levels: a pre-wake low flag (bus well below the supply), a pre-wake high flag (bus back near the supply) and a dominant flag. The local side sees the wake pin level. Each path gives a one-clock pulse to the mode controller when its request qualifies. All analogue thresholds are outside the block, and every time is a parameter counted in clock cycles.

A bus wake is an edge, a hold and an edge. The bus must go dominant, stay dominant for the bus filter time, and then be released. The low-power bus receiver runs only inside a bounded monitoring window, so a bus that floats between thresholds or is shorted to ground cannot keep it powered. After a floating-bus timeout, the bus path locks until the bus has been qualified high again. After a shorted-bus timeout, the next release still counts as a wake. The local path needs a qualified high level before each falling edge, so a pin that is stuck low gives one wake at most.

Top module: `bus_wake_qualifier`

## Requirements
- R1: Reset makes all outputs low. When `sleep_i` is sampled low, all three outputs are low in the following cycle and both paths return to their initial state: the bus path is armed, and the local path is waiting for a qualified high.
- R2: With the bus path armed and sleep active, a sampled `prewake_lo_i`=1 drives `rx_en_o` high in the next cycle.
- R3: With the receiver window open, a run of at least BUS_FILT_CYC consecutive samples with `dom_i`=1, followed by a sample with `dom_i`=0, gives `remote_wake_o`=1 in the next cycle. In that same cycle `rx_en_o` is low.
- R4: A dominant run shorter than BUS_FILT_CYC samples, followed by `dom_i`=0, gives no remote pulse. The bus path returns to armed.
- R5: `rx_en_o` is never high for more than MON_CYC consecutive cycles. When the window expires with `prewake_lo_i`=1 and `dom_i`=0 (a floating bus), the receiver turns off and the bus path locks.
- R6: While locked, bus activity gives no remote pulse and no receiver enable. The lock clears only after `prewake_hi_i`=1 has been sampled for REARM_CYC consecutive cycles.
- R7: When the window expires with `dom_i`=1 (a bus shorted to ground), the receiver turns off. The next sample with `dom_i`=0 gives `remote_wake_o`=1 in the following cycle.
- R8: When the local path is armed, WAKE_FILT_CYC consecutive samples with `wake_pin_i`=0 give `local_wake_o`=1 in the cycle after the last of them.
- R9: The local path arms only after PIN_HIGH_CYC consecutive samples with `wake_pin_i`=1. This applies after sleep entry, after each local pulse, and after a low run cut short by a high sample. A pin held low gives no second pulse.
- R10: Each wake pulse lasts exactly one cycle. The remote and local pulses are independent and may be high in the same cycle.
- R11: If the release sample (`dom_i`=0 after a qualified run) falls in the last cycle of the monitoring window, the wake is still given and the timeout is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | High while the transceiver is in its sleep state |
| prewake_lo_i | input | 1 | Bus below the pre-wake low threshold |
| prewake_hi_i | input | 1 | Bus above the pre-wake high threshold |
| dom_i | input | 1 | Bus at dominant level |
| wake_pin_i | input | 1 | Local wake-switch pin level (1 = high) |
| rx_en_o | output | 1 | Low-power bus receiver enable |
| remote_wake_o | output | 1 | One-cycle pulse for a qualified bus wake |
| local_wake_o | output | 1 | One-cycle pulse for a qualified pin wake |

## Verification
Two bus-path events can land in the same cycle: the release that closes a qualified dominant run, and the expiry of the monitoring window. The bench forces them together. It opens the window, holds the bus dominant for one cycle less than the window, and releases it on the last window cycle. It then requires a remote pulse with no lock afterward. A separate directed case ends a local low run and a bus release on the same sample, and both pulses must appear in the same cycle. A cycle-level reference model checks long random level sequences against all three outputs.

// File: rtl/wq_pkg.sv
`timescale 1ns/1ps
package wq_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_MON,
    RS_HOLD,
    RS_SHORT,
    RS_LOCK
  } rstate_t;

  typedef enum logic [1:0] {
    LS_REARM,
    LS_ARMED,
    LS_FILT
  } lstate_t;

  // Bits needed to hold values 0..max_val (at least one bit).
  function automatic int cnt_w(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wq_sat_cnt.sv
`timescale 1ns/1ps
module wq_sat_cnt #(
  parameter int W   = 4,
  parameter int MAX = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LIM = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_o <= '0;
    else if (inc && (cnt_o != LIM))
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wq_remote.sv
`timescale 1ns/1ps
module wq_remote
  import wq_pkg::*;
#(
  parameter int BUS_FILT_CYC = 1800,
  parameter int MON_CYC      = 200000,
  parameter int REARM_CYC    = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic lo_i,
  input  logic hi_i,
  input  logic dom_i,
  output logic rx_en_o,
  output logic wake_o
);
  localparam int MW = cnt_w(MON_CYC - 1);
  localparam int FW = cnt_w(BUS_FILT_CYC);
  localparam int HW = cnt_w(REARM_CYC - 1);
  localparam logic [MW-1:0] MON_LAST = MW'(MON_CYC - 1);
  localparam logic [FW-1:0] RUN_MIN  = FW'(BUS_FILT_CYC);
  localparam logic [HW-1:0] HI_LAST  = HW'(REARM_CYC - 1);

  rstate_t st_q, st_d;
  logic    wake_d;
  logic    in_win, mon_end;
  logic    run_inc, hi_inc;
  logic [MW-1:0] mon_cnt;
  logic [FW-1:0] run_cnt;
  logic [HW-1:0] hi_cnt;

  assign in_win  = (st_q == RS_MON) || (st_q == RS_HOLD);
  assign mon_end = in_win && (mon_cnt == MON_LAST);
  assign run_inc = in_win && dom_i;
  assign hi_inc  = (st_q == RS_LOCK) && hi_i;

  // cycles spent with the receiver powered
  wq_sat_cnt #(.W(MW), .MAX(MON_CYC - 1)) u_mon (
    .clk(clk), .rst(rst), .clr(!sleep_i || !in_win), .inc(in_win), .cnt_o(mon_cnt)
  );

  // length of the current dominant run
  wq_sat_cnt #(.W(FW), .MAX(BUS_FILT_CYC)) u_run (
    .clk(clk), .rst(rst), .clr(!sleep_i || !run_inc), .inc(run_inc), .cnt_o(run_cnt)
  );

  // consecutive high-level samples while locked
  wq_sat_cnt #(.W(HW), .MAX(REARM_CYC - 1)) u_hi (
    .clk(clk), .rst(rst), .clr(!sleep_i || !hi_inc), .inc(hi_inc), .cnt_o(hi_cnt)
  );

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    if (!sleep_i) begin
      st_d = RS_IDLE;
    end else begin
      case (st_q)
        RS_IDLE:  if (lo_i) st_d = RS_MON;
        RS_MON: begin
          if (dom_i)         st_d = mon_end ? RS_SHORT : RS_HOLD;
          else if (!lo_i)    st_d = RS_IDLE;
          else if (mon_end)  st_d = RS_LOCK;
        end
        RS_HOLD: begin
          if (!dom_i) begin
            st_d   = RS_IDLE;
            wake_d = (run_cnt >= RUN_MIN);
          end else if (mon_end) begin
            st_d = RS_SHORT;
          end
        end
        RS_SHORT: begin
          if (!dom_i) begin
            st_d   = RS_IDLE;
            wake_d = 1'b1;
          end
        end
        RS_LOCK:  if (hi_i && (hi_cnt == HI_LAST)) st_d = RS_IDLE;
        default:  st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RS_IDLE;
      rx_en_o <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      rx_en_o <= (st_d == RS_MON) || (st_d == RS_HOLD);
      wake_o  <= wake_d;
    end
  end
endmodule

// File: rtl/wq_local.sv
`timescale 1ns/1ps
module wq_local
  import wq_pkg::*;
#(
  parameter int WAKE_FILT_CYC = 700,
  parameter int PIN_HIGH_CYC  = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic pin_i,
  output logic wake_o
);
  localparam int CMAX = max2(PIN_HIGH_CYC - 1, WAKE_FILT_CYC - 1);
  localparam int CW   = cnt_w(CMAX);
  localparam logic [CW-1:0] PH_LAST = CW'(PIN_HIGH_CYC - 1);
  localparam logic [CW-1:0] WF_LAST = CW'(WAKE_FILT_CYC - 1);

  lstate_t ls_q, ls_d;
  logic    wake_d, c_clr, c_inc;
  logic [CW-1:0] cnt;

  wq_sat_cnt #(.W(CW), .MAX(CMAX)) u_cnt (
    .clk(clk), .rst(rst), .clr(c_clr), .inc(c_inc), .cnt_o(cnt)
  );

  always_comb begin
    ls_d   = ls_q;
    wake_d = 1'b0;
    c_clr  = 1'b0;
    c_inc  = 1'b0;
    if (!sleep_i) begin
      ls_d  = LS_REARM;
      c_clr = 1'b1;
    end else begin
      case (ls_q)
        LS_REARM: begin
          if (pin_i) begin
            if (cnt == PH_LAST) begin
              ls_d  = LS_ARMED;
              c_clr = 1'b1;
            end else begin
              c_inc = 1'b1;
            end
          end else begin
            c_clr = 1'b1;
          end
        end
        LS_ARMED: begin
          if (!pin_i) begin
            ls_d  = LS_FILT;
            c_inc = 1'b1;
          end
        end
        LS_FILT: begin
          if (!pin_i) begin
            if (cnt >= WF_LAST) begin
              wake_d = 1'b1;
              ls_d   = LS_REARM;
              c_clr  = 1'b1;
            end else begin
              c_inc = 1'b1;
            end
          end else begin
            ls_d  = LS_REARM;
            c_clr = 1'b1;
          end
        end
        default: begin
          ls_d  = LS_REARM;
          c_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q   <= LS_REARM;
      wake_o <= 1'b0;
    end else begin
      ls_q   <= ls_d;
      wake_o <= wake_d;
    end
  end
endmodule

// File: rtl/bus_wake_qualifier.sv
`timescale 1ns/1ps
module bus_wake_qualifier #(
  parameter int BUS_FILT_CYC  = 1800,
  parameter int MON_CYC       = 200000,
  parameter int REARM_CYC     = 60,
  parameter int WAKE_FILT_CYC = 700,
  parameter int PIN_HIGH_CYC  = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic prewake_lo_i,
  input  logic prewake_hi_i,
  input  logic dom_i,
  input  logic wake_pin_i,
  output logic rx_en_o,
  output logic remote_wake_o,
  output logic local_wake_o
);
  wq_remote #(
    .BUS_FILT_CYC(BUS_FILT_CYC),
    .MON_CYC     (MON_CYC),
    .REARM_CYC   (REARM_CYC)
  ) u_remote (
    .clk    (clk),
    .rst    (rst),
    .sleep_i(sleep_i),
    .lo_i   (prewake_lo_i),
    .hi_i   (prewake_hi_i),
    .dom_i  (dom_i),
    .rx_en_o(rx_en_o),
    .wake_o (remote_wake_o)
  );

  wq_local #(
    .WAKE_FILT_CYC(WAKE_FILT_CYC),
    .PIN_HIGH_CYC (PIN_HIGH_CYC)
  ) u_local (
    .clk    (clk),
    .rst    (rst),
    .sleep_i(sleep_i),
    .pin_i  (wake_pin_i),
    .wake_o (local_wake_o)
  );
endmodule

// File: rtl/wq_checker.sv
`timescale 1ns/1ps
module wq_checker #(
  parameter int MON_CYC = 200000
) (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic prewake_lo_i,
  input logic dom_i,
  input logic wake_pin_i,
  input logic rx_en_o,
  input logic remote_wake_o,
  input logic local_wake_o
);
  int unsigned on_run;

  always_ff @(posedge clk) begin
    if (rst)          on_run <= 0;
    else if (rx_en_o) on_run <= on_run + 1;
    else              on_run <= 0;
  end

  // R1
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> (!rx_en_o && !remote_wake_o && !local_wake_o));

  // R2
  rx_en_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en_o) |-> ($past(prewake_lo_i) && $past(sleep_i)));

  // R3
  remote_release_chk: assert property (@(posedge clk) disable iff (rst)
    remote_wake_o |-> (!$past(dom_i) && $past(dom_i, 2) && !rx_en_o));

  // R5
  rx_en_window_chk: assert property (@(posedge clk) disable iff (rst)
    rx_en_o |-> (on_run < MON_CYC));

  // R8
  local_low_chk: assert property (@(posedge clk) disable iff (rst)
    local_wake_o |-> (!$past(wake_pin_i) && $past(sleep_i)));

  // R10
  remote_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    remote_wake_o |=> !remote_wake_o);

  // R10
  local_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    local_wake_o |=> !local_wake_o);
endmodule

bind bus_wake_qualifier wq_checker #(.MON_CYC(MON_CYC)) u_wq_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_i      (sleep_i),
  .prewake_lo_i (prewake_lo_i),
  .dom_i        (dom_i),
  .wake_pin_i   (wake_pin_i),
  .rx_en_o      (rx_en_o),
  .remote_wake_o(remote_wake_o),
  .local_wake_o (local_wake_o)
);

// File: tb/tb_bus_wake_qualifier.sv
`timescale 1ns/1ps
module tb_bus_wake_qualifier;
  localparam int BF = 4;
  localparam int MON = 20;
  localparam int RA = 3;
  localparam int WF = 5;
  localparam int PH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0;
  logic lo = 1'b0, hi = 1'b1, dom = 1'b0, pin = 1'b1;
  logic rx_en, rwake, lwake;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_wake_qualifier #(
    .BUS_FILT_CYC(BF), .MON_CYC(MON), .REARM_CYC(RA),
    .WAKE_FILT_CYC(WF), .PIN_HIGH_CYC(PH)
  ) dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i),
    .prewake_lo_i(lo), .prewake_hi_i(hi), .dom_i(dom), .wake_pin_i(pin),
    .rx_en_o(rx_en), .remote_wake_o(rwake), .local_wake_o(lwake)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // bus level: 0 recessive, 1 between thresholds, 2 floating low, 3 dominant
  task automatic bus(input int lvl);
    hi  = (lvl == 0);
    lo  = (lvl >= 2);
    dom = (lvl == 3);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // ---------------- reference model, built from the requirements ----------------
  int m_rs, m_mon, m_run, m_hi, m_ls, m_lc;
  bit e_rx, e_rw, e_lw;

  always @(posedge clk) begin
    int ns, nls;
    bit rw, lw, to;
    if (rst || !sleep_i) begin
      m_rs = 0; m_mon = 0; m_run = 0; m_hi = 0; m_ls = 0; m_lc = 0;
      e_rx = 0; e_rw = 0; e_lw = 0;
    end else begin
      rw = 0; ns = m_rs;
      to = ((m_rs == 1 || m_rs == 2) && m_mon == MON - 1);
      case (m_rs)
        0: if (lo) ns = 1;
        1: begin
          if (dom) ns = to ? 3 : 2;
          else if (!lo) ns = 0;
          else if (to) ns = 4;
        end
        2: begin
          if (!dom) begin ns = 0; rw = (m_run >= BF); end
          else if (to) ns = 3;
        end
        3: if (!dom) begin ns = 0; rw = 1; end
        4: if (hi && m_hi == RA - 1) ns = 0;
        default: ns = 0;
      endcase
      m_run = ((m_rs == 1 || m_rs == 2) && dom) ? ((m_run < BF) ? m_run + 1 : BF) : 0;
      m_hi  = (m_rs == 4 && hi) ? ((m_hi < RA - 1) ? m_hi + 1 : RA - 1) : 0;
      m_mon = (m_rs == 1 || m_rs == 2) ? m_mon + 1 : 0;
      m_rs  = ns;

      lw = 0; nls = m_ls;
      case (m_ls)
        0: if (pin) begin
             if (m_lc == PH - 1) begin nls = 1; m_lc = 0; end else m_lc++;
           end else m_lc = 0;
        1: if (!pin) begin nls = 2; m_lc = 1; end
        default: if (!pin) begin
             if (m_lc + 1 >= WF) begin lw = 1; nls = 0; m_lc = 0; end else m_lc++;
           end else begin nls = 0; m_lc = 0; end
      endcase
      m_ls = nls;
      e_rx = (m_rs == 1 || m_rs == 2);
      e_rw = rw;
      e_lw = lw;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R5 model rx_en", rx_en, e_rx);
      chk("R3 model remote_wake", rwake, e_rw);
      chk("R8 model local_wake", lwake, e_lw);
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int bus_left, pin_left, lvl;
    void'($urandom(32'd20240611));
    bus(0);
    tick(3);
    rst = 1'b0;
    tick(1);
    cmp_en = 1'b1;
    chk("R1 reset rx_en", rx_en, 1'b0);
    chk("R1 reset remote", rwake, 1'b0);
    chk("R1 reset local", lwake, 1'b0);
    bus(2); tick(2);
    chk("R1 awake ignores pre-wake", rx_en, 1'b0);

    sleep_i = 1'b1; bus(0); pin = 1'b1; tick(4);

    // R2 / R3: qualified remote wake
    bus(2); tick(1);
    chk("R2 receiver on", rx_en, 1'b1);
    bus(3); tick(BF);
    chk("R3 no pulse during hold", rwake, 1'b0);
    bus(0); tick(1);
    chk("R3 remote pulse", rwake, 1'b1);
    chk("R3 receiver off after wake", rx_en, 1'b0);
    tick(1);
    chk("R10 remote one cycle", rwake, 1'b0);

    // R4: short dominant run
    bus(2); tick(1);
    bus(3); tick(BF - 1);
    bus(0); tick(1);
    chk("R4 short run no pulse", rwake, 1'b0);
    chk("R4 receiver off", rx_en, 1'b0);
    tick(1);

    // R5 / R6: floating bus timeout and lock
    bus(2); tick(MON);
    chk("R5 receiver on for full window", rx_en, 1'b1);
    tick(1);
    chk("R5 receiver off after floating timeout", rx_en, 1'b0);
    tick(5);
    bus(3); tick(6);
    bus(1); tick(1);
    chk("R6 locked no remote", rwake, 1'b0);
    chk("R6 locked receiver off", rx_en, 1'b0);
    bus(0); tick(RA - 1);
    bus(1); tick(1);
    bus(2); tick(1);
    chk("R6 broken high run keeps lock", rx_en, 1'b0);
    bus(0); tick(RA);
    bus(2); tick(1);
    chk("R6 re-armed after high run", rx_en, 1'b1);
    bus(0); tick(2);

    // R7: short to ground
    bus(2); tick(1);
    bus(3); tick(MON - 1);
    chk("R7 receiver on before expiry", rx_en, 1'b1);
    tick(1);
    chk("R7 receiver off on dominant timeout", rx_en, 1'b0);
    chk("R7 no pulse at timeout", rwake, 1'b0);
    tick(5);
    chk("R7 still no pulse while shorted", rwake, 1'b0);
    bus(0); tick(1);
    chk("R7 release after short gives pulse", rwake, 1'b1);
    tick(1);

    // R11: release in last window cycle
    bus(2); tick(1);
    bus(3); tick(MON - 1);
    chk("R11 window still open", rx_en, 1'b1);
    bus(0); tick(1);
    chk("R11 release beats timeout", rwake, 1'b1);
    tick(1);
    bus(2); tick(1);
    chk("R11 no lock afterward", rx_en, 1'b1);
    bus(0); tick(2);

    // R8 / R9: local path (armed since sleep entry)
    pin = 1'b0; tick(WF - 1);
    chk("R8 no pulse before filter", lwake, 1'b0);
    tick(1);
    chk("R8 local pulse", lwake, 1'b1);
    tick(1);
    chk("R10 local one cycle", lwake, 1'b0);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk("R9 held low no repeat", lwake, 1'b0);
    end
    pin = 1'b1; tick(PH - 1);
    pin = 1'b0; tick(WF + 1);
    chk("R9 short high does not re-arm", lwake, 1'b0);
    pin = 1'b1; tick(PH);
    pin = 1'b0; tick(WF);
    chk("R8 pulse after re-arm", lwake, 1'b1);
    pin = 1'b1; tick(PH);
    pin = 1'b0; tick(WF - 2);
    pin = 1'b1; tick(1);
    pin = 1'b0; tick(WF);
    chk("R9 aborted filter needs re-arm", lwake, 1'b0);
    pin = 1'b1; tick(PH);

    // R10: coincident remote and local pulses
    bus(2); tick(1);
    pin = 1'b0; bus(3); tick(BF);
    bus(0); tick(1);
    chk("R10 coincident remote", rwake, 1'b1);
    chk("R10 coincident local", lwake, 1'b1);
    pin = 1'b1; tick(1);

    // R1: leaving sleep mid-window
    bus(2); tick(1);
    chk("R2 receiver on again", rx_en, 1'b1);
    sleep_i = 1'b0; tick(1);
    chk("R1 sleep exit clears receiver", rx_en, 1'b0);
    sleep_i = 1'b1; bus(0); tick(2);

    // random phase checked against the model
    bus_left = 0; pin_left = 0; lvl = 0;
    for (int c = 0; c < 6000; c++) begin
      if (bus_left == 0) begin
        lvl = $urandom_range(0, 3);
        bus(lvl);
        bus_left = $urandom_range(1, 30);
      end
      if (pin_left == 0) begin
        pin = $urandom_range(0, 1);
        pin_left = $urandom_range(1, 12);
      end
      sleep_i = ($urandom_range(0, 299) != 0);
      bus_left--; pin_left--;
      tick(1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule